// File: doc/BRIEF.md
# Stereo Audio Sample Serializer

This block turns a pair of 24-bit two's-complement audio samples (left and right) into one serial data line. Each frame is 64 bit-clock periods long, 32 per channel. Samples go out most significant bit first. The block runs entirely on the fast system clock. It watches the bit clock through a one-cycle strobe that marks each falling edge, and it samples the word-select (channel) clock as a level. These two signals may be generated on chip or supplied from outside; the block treats both cases the same way. It uses word-select transitions to find the channel boundaries and to decide when to load new samples.

The frame format is chosen once per reset, from the level that an external pull resistor holds on the data pin. While that level is read, the pin is still undriven. For a fixed number of system-clock cycles after reset release, the output enable stays low. At the end of that window, the pin level is latched as the format: high selects I2S, low selects left-justified. From then on the block drives the pin. At the start of every left half-frame it captures both channel inputs together and pulses a request, so that the source can present the next pair.

Top module: `audio_ser_top`

## Requirements
- R1: From reset until STRAP_DLY system-clock cycles after reset release, sd_oe_o is 0 and sd_o is 0. sd_oe_o rises on the STRAP_DLY-th rising clock edge with reset low.
- R2: The strap_i level present on that edge selects the format, and the choice then holds until the next reset: 1 selects I2S, 0 selects left-justified.
- R3: Each 32-bit channel slot carries its 24-bit sample MSB first. In left-justified format, bit 23 occupies slot position 0, the bit period that starts at the falling edge where word-select changes. In I2S format, bit 23 occupies slot position 1.
- R4: In I2S format, word-select low marks the left channel. In left-justified format, word-select high marks the left channel.
- R5: Every slot position that carries no sample bit is driven 0. In left-justified format these are positions 24 to 31. In I2S format they are position 0 and positions 25 to 31.
- R6: sd_o changes only on the system-clock cycle that follows a cycle in which sclk_fall_i is high.
- R7: Both samples are captured at the first bit of each left slot. req_o is high for exactly one cycle at that moment. Input changes at any other time do not affect the frame in progress.
- R8: If word-select does not change, the channel flips by itself after 32 bit periods, so a 64-period frame keeps running.
- R9: A word-select change that arrives at any other slot position restarts the slot at position 0. The new channel follows the level of word-select.
- R10: Before the format is latched, bit-clock strobes and word-select changes have no effect: req_o stays 0 and sd_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (master) clock |
| rst | input | 1 | Synchronous reset, active high |
| strap_i | input | 1 | Level seen on the data pin while it is undriven |
| sclk_fall_i | input | 1 | One-cycle strobe for each bit-clock falling edge |
| lrck_i | input | 1 | Word-select level, sampled on strobe cycles |
| left_i | input | 24 | Left channel sample, two's complement |
| right_i | input | 24 | Right channel sample, two's complement |
| sd_o | output | 1 | Serial data out |
| sd_oe_o | output | 1 | Output enable for the data pin driver |
| req_o | output | 1 | Pulse: sample pair captured, present the next one |

## Verification
A wrong bit position or a wrong slot counter appears on sd_o within one bit period of the slot start, as a shifted or misplaced MSB. A wrong channel state exchanges the left and right words in the very next slot. A stale or lost word-select history shows up at the next word-select change as a missed or false realignment, or, in free-running frames, as a channel flip on the wrong bit. A capture register loaded at the wrong moment puts data on the line that differs from the pair presented when req_o pulsed. A wrong format latch shifts every sample by one bit from the first slot onward.

// File: rtl/audio_ser_pkg.sv
package audio_ser_pkg;

    typedef enum logic {
        FMT_LJ  = 1'b0,
        FMT_I2S = 1'b1
    } fmt_e;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    // Channel that a given word-select level denotes under a format.
    function automatic chan_e chan_of_level(fmt_e fmt, logic level);
        if (fmt == FMT_I2S)
            return level ? CH_RIGHT : CH_LEFT;
        return level ? CH_LEFT : CH_RIGHT;
    endfunction

    function automatic chan_e other_chan(chan_e ch);
        return (ch == CH_LEFT) ? CH_RIGHT : CH_LEFT;
    endfunction

endpackage

// File: rtl/ser_strap_latch.sv
module ser_strap_latch
    import audio_ser_pkg::*;
#(
    parameter int STRAP_DLY = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic strap_i,
    output fmt_e fmt_o,
    output logic active_o
);
    localparam int CW = $clog2(STRAP_DLY + 1);

    logic [CW-1:0] wait_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q   <= '0;
            active_o <= 1'b0;
            fmt_o    <= FMT_LJ;
        end else if (!active_o) begin
            if (wait_q == CW'(STRAP_DLY - 1)) begin
                active_o <= 1'b1;
                fmt_o    <= fmt_e'(strap_i);
            end else begin
                wait_q <= wait_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ser_frame_track.sv
module ser_frame_track
    import audio_ser_pkg::*;
#(
    parameter int SLOT_BITS = 32,
    parameter int PW        = $clog2(SLOT_BITS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active_i,
    input  fmt_e          fmt_i,
    input  logic          fall_i,
    input  logic          lrck_i,
    output logic          adv_o,
    output logic [PW-1:0] nxt_pos_o,
    output chan_e         nxt_ch_o,
    output logic          left_start_o
);
    localparam logic [PW-1:0] LAST = PW'(SLOT_BITS - 1);

    logic          prev_q;
    logic [PW-1:0] pos_q;
    chan_e         ch_q;
    logic          ws_edge;

    assign adv_o   = active_i && fall_i;
    assign ws_edge = (lrck_i != prev_q);

    always_comb begin
        nxt_pos_o = pos_q;
        nxt_ch_o  = ch_q;
        if (adv_o) begin
            if (ws_edge) begin
                nxt_pos_o = '0;
                nxt_ch_o  = chan_of_level(fmt_i, lrck_i);
            end else if (pos_q == LAST) begin
                nxt_pos_o = '0;
                nxt_ch_o  = other_chan(ch_q);
            end else begin
                nxt_pos_o = pos_q + 1'b1;
            end
        end
    end

    assign left_start_o = adv_o && (nxt_pos_o == '0) && (nxt_ch_o == CH_LEFT);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= lrck_i;
            pos_q  <= LAST;
            ch_q   <= CH_RIGHT;
        end else begin
            if (!active_i || fall_i)
                prev_q <= lrck_i;
            pos_q <= nxt_pos_o;
            ch_q  <= nxt_ch_o;
        end
    end
endmodule

// File: rtl/ser_word_store.sv
module ser_word_store
    import audio_ser_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_i,
    input  chan_e               ch_i,
    input  logic [SAMPLE_W-1:0] left_i,
    input  logic [SAMPLE_W-1:0] right_i,
    output logic [SAMPLE_W-1:0] word_o,
    output logic                req_o
);
    logic [SAMPLE_W-1:0] left_q, right_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q  <= '0;
            right_q <= '0;
            req_o   <= 1'b0;
        end else begin
            req_o <= load_i;
            if (load_i) begin
                left_q  <= left_i;
                right_q <= right_i;
            end
        end
    end

    // The slot being entered may need the pair arriving this very cycle.
    always_comb begin
        if (load_i)
            word_o = (ch_i == CH_LEFT) ? left_i : right_i;
        else
            word_o = (ch_i == CH_LEFT) ? left_q : right_q;
    end
endmodule

// File: rtl/ser_bit_out.sv
module ser_bit_out
    import audio_ser_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int PW       = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                active_i,
    input  logic                adv_i,
    input  fmt_e                fmt_i,
    input  logic [PW-1:0]       pos_i,
    input  logic [SAMPLE_W-1:0] word_i,
    output logic                sd_o,
    output logic                sd_oe_o
);
    logic [PW:0]         lead;
    logic [PW:0]         pos_ext;
    logic [PW:0]         rel;
    logic [SAMPLE_W-1:0] shifted;
    logic                bit_nxt;

    assign lead    = (fmt_i == FMT_I2S) ? (PW+1)'(1) : '0;
    assign pos_ext = {1'b0, pos_i};
    assign rel     = pos_ext - lead;
    assign shifted = word_i << rel;

    always_comb begin
        if (pos_ext < lead || rel >= (PW+1)'(SAMPLE_W))
            bit_nxt = 1'b0;
        else
            bit_nxt = shifted[SAMPLE_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst)
            sd_o <= 1'b0;
        else if (adv_i)
            sd_o <= bit_nxt;
    end

    assign sd_oe_o = active_i;
endmodule

// File: rtl/audio_ser_top.sv
module audio_ser_top
    import audio_ser_pkg::*;
#(
    parameter int SAMPLE_W  = 24,
    parameter int SLOT_BITS = 32,
    parameter int STRAP_DLY = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                strap_i,
    input  logic                sclk_fall_i,
    input  logic                lrck_i,
    input  logic [SAMPLE_W-1:0] left_i,
    input  logic [SAMPLE_W-1:0] right_i,
    output logic                sd_o,
    output logic                sd_oe_o,
    output logic                req_o
);
    localparam int PW = $clog2(SLOT_BITS);

    fmt_e                fmt;
    logic                active;
    logic                adv;
    logic [PW-1:0]       nxt_pos;
    chan_e               nxt_ch;
    logic                left_start;
    logic [SAMPLE_W-1:0] word;

    ser_strap_latch #(.STRAP_DLY(STRAP_DLY)) strap_i0 (
        .clk(clk), .rst(rst), .strap_i(strap_i),
        .fmt_o(fmt), .active_o(active)
    );

    ser_frame_track #(.SLOT_BITS(SLOT_BITS), .PW(PW)) track_i0 (
        .clk(clk), .rst(rst), .active_i(active), .fmt_i(fmt),
        .fall_i(sclk_fall_i), .lrck_i(lrck_i), .adv_o(adv),
        .nxt_pos_o(nxt_pos), .nxt_ch_o(nxt_ch), .left_start_o(left_start)
    );

    ser_word_store #(.SAMPLE_W(SAMPLE_W)) store_i0 (
        .clk(clk), .rst(rst), .load_i(left_start), .ch_i(nxt_ch),
        .left_i(left_i), .right_i(right_i), .word_o(word), .req_o(req_o)
    );

    ser_bit_out #(.SAMPLE_W(SAMPLE_W), .PW(PW)) out_i0 (
        .clk(clk), .rst(rst), .active_i(active), .adv_i(adv), .fmt_i(fmt),
        .pos_i(nxt_pos), .word_i(word), .sd_o(sd_o), .sd_oe_o(sd_oe_o)
    );
endmodule

// File: rtl/audio_ser_chk.sv
module audio_ser_chk (
    input logic clk,
    input logic rst,
    input logic sclk_fall_i,
    input logic sd_o,
    input logic sd_oe_o,
    input logic req_o
);
    assert_quiet_while_undriven_R1: assert property (@(posedge clk) disable iff (rst)
        !sd_oe_o |-> !sd_o);

    assert_enable_holds_R2: assert property (@(posedge clk) disable iff (rst)
        sd_oe_o |=> sd_oe_o);

    assert_data_moves_after_fall_R6: assert property (@(posedge clk) disable iff (rst)
        (sd_oe_o && $past(sd_oe_o) && !$past(sclk_fall_i)) |-> $stable(sd_o));

    assert_req_single_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        req_o |=> !req_o);

    assert_req_follows_fall_R7: assert property (@(posedge clk) disable iff (rst)
        req_o |-> $past(sclk_fall_i));

    assert_no_req_before_strap_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(sd_oe_o) |-> !req_o);
endmodule

bind audio_ser_top audio_ser_chk chk_i (
    .clk(clk), .rst(rst), .sclk_fall_i(sclk_fall_i),
    .sd_o(sd_o), .sd_oe_o(sd_oe_o), .req_o(req_o)
);

// File: tb/audio_ser_top_tb_top.sv
`timescale 1ns/1ps
module audio_ser_top_tb_top;
    localparam int W   = 24;
    localparam int DLY = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          strap = 1'b0;
    logic          fall = 1'b0;
    logic          lrck = 1'b0;
    logic [W-1:0]  left_in = '0;
    logic [W-1:0]  right_in = '0;
    logic          sd, sd_oe, req;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    string tag = "R1";

    always #2 clk = ~clk;

    audio_ser_top #(.SAMPLE_W(W), .SLOT_BITS(32), .STRAP_DLY(DLY)) dut_i (
        .clk(clk), .rst(rst), .strap_i(strap), .sclk_fall_i(fall),
        .lrck_i(lrck), .left_i(left_in), .right_i(right_in),
        .sd_o(sd), .sd_oe_o(sd_oe), .req_o(req)
    );

    // Behavioural reference, updated on each rising edge.
    int           m_cnt, m_pos, k;
    bit           m_act, m_i2s, m_inleft, m_prev;
    logic [W-1:0] m_wl, m_wr, w;
    bit           e_sd, e_oe, e_req;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_act = 0; m_i2s = 0; m_pos = 31; m_inleft = 0;
            m_prev = lrck; m_wl = '0; m_wr = '0; e_sd = 0; e_req = 0;
        end else if (!m_act) begin
            e_req = 0;
            m_prev = lrck;
            if (m_cnt == DLY - 1) begin m_act = 1; m_i2s = strap; end
            else m_cnt++;
        end else begin
            e_req = 0;
            if (fall) begin
                if (lrck != m_prev) begin
                    m_pos = 0;
                    m_inleft = m_i2s ? !lrck : lrck;
                end else if (m_pos == 31) begin
                    m_pos = 0;
                    m_inleft = !m_inleft;
                end else begin
                    m_pos++;
                end
                m_prev = lrck;
                if (m_pos == 0 && m_inleft) begin
                    m_wl = left_in; m_wr = right_in; e_req = 1;
                end
                k = m_pos - (m_i2s ? 1 : 0);
                w = m_inleft ? m_wl : m_wr;
                e_sd = (k >= 0 && k < W) ? w[W-1-k] : 1'b0;
            end
        end
        e_oe = m_act;
    end

    always @(negedge clk) begin
        n_cmp++;
        if (sd !== e_sd || sd_oe !== e_oe || req !== e_req) begin
            n_bad++;
            $display("FAIL %s cyc %0d: sd/oe/req actual %b%b%b expected %b%b%b",
                     tag, cyc, sd, sd_oe, req, e_sd, e_oe, e_req);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // One bit period: four system clocks, strobe on the first.
    task automatic sclk_bit(input bit toggle);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            fall = (i == 0);
            if (i == 0 && toggle) lrck = ~lrck;
            if (req) begin
                left_in  = $urandom;
                right_in = $urandom;
            end
        end
    endtask

    // A slot of n bit periods, word-select change on its first one.
    task automatic slot(input int n, input bit toggle);
        for (int b = 0; b < n; b++) sclk_bit(toggle && b == 0);
    endtask

    task automatic apply_reset(input bit s);
        @(negedge clk);
        rst = 1; strap = s; fall = 0;
        repeat (4) @(negedge clk);
        rst = 0;
    endtask

    initial begin
        left_in = 24'h800000; right_in = 24'h7FFFFF;
        tag = "R1 reset state";
        apply_reset(1'b0);
        tag = "R1 R10 strobes before strap";
        sclk_bit(1); sclk_bit(0);
        tag = "R2 R3 R4 R5 R7 left-justified frames";
        for (int f = 0; f < 6; f++) begin slot(32, 1); slot(32, 1); end
        tag = "R8 free-running word select";
        slot(32, 1); slot(32, 0); slot(32, 0); slot(32, 0);
        tag = "R9 early word-select change";
        slot(10, 1); slot(32, 1); slot(5, 1); slot(32, 1); slot(32, 1);
        tag = "R6 stable data between strobes";
        for (int f = 0; f < 2; f++) begin slot(32, 1); slot(32, 1); end

        left_in = 24'h000001; right_in = 24'hFFFFFF;
        tag = "R1 R2 reset with strap high";
        apply_reset(1'b1);
        tag = "R10 strobes before strap";
        sclk_bit(1); sclk_bit(1);
        tag = "R3 R4 R5 R7 I2S frames";
        for (int f = 0; f < 6; f++) begin slot(32, 1); slot(32, 1); end
        tag = "R8 I2S free-running";
        slot(32, 1); slot(32, 0); slot(32, 0);
        tag = "R9 I2S realign";
        slot(17, 1); slot(32, 1); slot(32, 1);
        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule